// File: doc/BRIEF.md
# Vector Register Mix and Swizzle Unit

This unit is the register-to-register data path of a four-lane vector processor. A register is a 64-bit vector of four 16-bit words: X in lane 0 (bits 15:0), Y in lane 1 (bits 31:16), Z in lane 2 (bits 47:32) and W in lane 3 (bits 63:48). The decoder gives the unit four things:

- the 4-bit opcode;
- two 4-bit instruction fields, called the extra field and the source field;
- the current source register value;
- the current destination register value.

The unit returns the new destination value and a per-word write enable for the register file.

There are two operations. A masked move (mix, opcode 0x4) blends the source register into the destination. Each extra-field bit that is set keeps the matching destination word. A swizzle (opcode 0x5) rebuilds the destination from its own words. Four 2-bit lane selectors, taken from the source and extra fields of the instruction, pick the word for each lane. The swizzle does not read the source register value.

The result is computed combinationally and then registered. A small controller with two states handles the timing:

- **ST_IDLE**: no result is shown.
- **ST_EMIT**: the registered result is shown with `out_valid` high.

The controller has four transitions:

- **T_ACCEPT**: ST_IDLE to ST_EMIT, on a valid request with a supported opcode.
- **T_CHAIN**: ST_EMIT to ST_EMIT, on a back-to-back supported request.
- **T_DRAIN**: ST_EMIT to ST_IDLE, when no supported request arrives.
- **T_WAIT**: ST_IDLE to ST_IDLE, when no supported request arrives.

Top module: `vsu_top`

## Requirements
- R1: While `rst_n` is low and after its release with no request, `out_valid` is 0, `out_wen` is 4'b0000 and `out_data` is all zeros.
- R2: For opcode 0x4, result lane i equals destination lane i when `ext_field[i]` is 1, and equals source lane i when it is 0. Bit 0 masks X, bit 1 Y, bit 2 Z and bit 3 W.
- R3: For opcode 0x4, `out_wen` equals the bitwise inverse of `ext_field`.
- R4: For opcode 0x5, result lane i is destination word number sel_i, where word codes are X=0, Y=1, Z=2, W=3. The selectors are: X lane from `ext_field[1:0]`, Y lane from `ext_field[3:2]`, Z lane from `src_field[1:0]`, W lane from `src_field[3:2]`. All lanes read the old destination value, and one word may feed several lanes.
- R5: For opcode 0x5, `out_wen` is 4'b1111.
- R6: A request sampled with `in_valid` high and a supported opcode shows its result with `out_valid` high on the next cycle. `out_valid` stays high only for that one cycle unless another supported request follows at once. Back-to-back requests give results on consecutive cycles.
- R7: A request with any opcode other than 0x4 or 0x5, or with `in_valid` low, produces no `out_valid`, and `out_data` keeps its previous value.
- R8: The swizzle result does not depend on `src_reg`.
- R9: Whenever `out_valid` is 0, `out_wen` is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_code | input | 4 | Decoded opcode (0x4 mix, 0x5 swizzle) |
| ext_field | input | 4 | Extra field: mix keep mask, or X/Y selectors |
| src_field | input | 4 | Source field: Z/W selectors for swizzle |
| src_reg | input | 64 | Source register value |
| dst_reg | input | 64 | Current destination register value |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 64 | New destination value |
| out_wen | output | 4 | Per-word write enable, bit i for lane i |

## Verification
On every cycle, the assertions check the controller timing:

- a supported request is followed by `out_valid`, and any other input is not;
- `out_data` is held when nothing is accepted;
- the write-enable pattern for each opcode is correct;
- `out_wen` is zero whenever `out_valid` is low.

The word contents themselves can only be shown by the bench's scenarios. The bench compares them against its own mix and swizzle models for:

- every mask;
- repeated-selector swizzles such as broadcasting one word;
- changing `src_reg` under a swizzle;
- illegal opcodes between valid requests.

// File: rtl/vsu_pkg.sv
package vsu_pkg;
    localparam int LANES = 4;
    localparam int SEL_W = 2;

    localparam logic [3:0] OPC_MIX = 4'h4;
    localparam logic [3:0] OPC_SWZ = 4'h5;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } vsu_state_e;
endpackage

// File: rtl/vsu_mix.sv
module vsu_mix #(
    parameter int LANE_W = 16
) (
    input  logic [3:0]                         keep_mask,
    input  logic [vsu_pkg::LANES*LANE_W-1:0]   src_vec,
    input  logic [vsu_pkg::LANES*LANE_W-1:0]   dst_vec,
    output logic [vsu_pkg::LANES*LANE_W-1:0]   mix_vec,
    output logic [3:0]                         mix_wen
);
    for (genvar g = 0; g < vsu_pkg::LANES; g++) begin : g_lane
        always_comb begin
            if (keep_mask[g]) begin
                mix_vec[g*LANE_W +: LANE_W] = dst_vec[g*LANE_W +: LANE_W];
            end else begin
                mix_vec[g*LANE_W +: LANE_W] = src_vec[g*LANE_W +: LANE_W];
            end
            mix_wen[g] = ~keep_mask[g];
        end
    end
endmodule

// File: rtl/vsu_swizzle.sv
module vsu_swizzle #(
    parameter int LANE_W = 16
) (
    input  logic [vsu_pkg::LANES*vsu_pkg::SEL_W-1:0] sel_pack,
    input  logic [vsu_pkg::LANES*LANE_W-1:0]         dst_vec,
    output logic [vsu_pkg::LANES*LANE_W-1:0]         swz_vec
);
    localparam int SW = vsu_pkg::SEL_W;

    for (genvar g = 0; g < vsu_pkg::LANES; g++) begin : g_lane
        logic [SW-1:0] sel;
        assign sel = sel_pack[g*SW +: SW];
        always_comb begin
            unique case (sel)
                2'd0:    swz_vec[g*LANE_W +: LANE_W] = dst_vec[0*LANE_W +: LANE_W];
                2'd1:    swz_vec[g*LANE_W +: LANE_W] = dst_vec[1*LANE_W +: LANE_W];
                2'd2:    swz_vec[g*LANE_W +: LANE_W] = dst_vec[2*LANE_W +: LANE_W];
                default: swz_vec[g*LANE_W +: LANE_W] = dst_vec[3*LANE_W +: LANE_W];
            endcase
        end
    end
endmodule

// File: rtl/vsu_top.sv
module vsu_top #(
    parameter int LANE_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [3:0]                          op_code,
    input  logic [3:0]                          ext_field,
    input  logic [3:0]                          src_field,
    input  logic [vsu_pkg::LANES*LANE_W-1:0]    src_reg,
    input  logic [vsu_pkg::LANES*LANE_W-1:0]    dst_reg,
    output logic                                out_valid,
    output logic [vsu_pkg::LANES*LANE_W-1:0]    out_data,
    output logic [3:0]                          out_wen
);
    import vsu_pkg::*;

    localparam int VEC_W = LANES * LANE_W;

    vsu_state_e       state_q, state_d;
    logic             accept;
    logic             is_mix;
    logic [VEC_W-1:0] mix_vec, swz_vec, res_d, data_q;
    logic [3:0]       mix_wen, wen_d, wen_q;

    vsu_mix #(.LANE_W(LANE_W)) u_mix (
        .keep_mask (ext_field),
        .src_vec   (src_reg),
        .dst_vec   (dst_reg),
        .mix_vec   (mix_vec),
        .mix_wen   (mix_wen)
    );

    vsu_swizzle #(.LANE_W(LANE_W)) u_swz (
        .sel_pack  ({src_field, ext_field}),
        .dst_vec   (dst_reg),
        .swz_vec   (swz_vec)
    );

    assign is_mix = (op_code == OPC_MIX);
    assign accept = in_valid && (is_mix || (op_code == OPC_SWZ));

    always_comb begin
        res_d = is_mix ? mix_vec : swz_vec;
        wen_d = is_mix ? mix_wen : 4'b1111;
    end

    // Next-state logic: T_ACCEPT / T_CHAIN on accept, T_DRAIN / T_WAIT otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = accept ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            wen_q  <= '0;
        end else begin
            if (accept) begin
                data_q <= res_d;
            end
            wen_q <= accept ? wen_d : 4'b0000;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
    assign out_data  = data_q;
    assign out_wen   = wen_q;

    // Assertions
    a_r6_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code == OPC_MIX || op_code == OPC_SWZ)) |=> out_valid);

    a_r7_no_accept_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && (op_code == OPC_MIX || op_code == OPC_SWZ)) |=> !out_valid);

    a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && (op_code == OPC_MIX || op_code == OPC_SWZ)) |=> $stable(out_data));

    a_r9_wen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_wen == 4'b0000));

    a_r5_swz_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OPC_SWZ) |=> (out_wen == 4'b1111));

    a_r3_mix_wen_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OPC_MIX) |=> (out_wen == ~$past(ext_field)));
endmodule

// File: tb/tb_vsu_top.sv
module tb_vsu_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  op_code, ext_field, src_field;
    logic [63:0] src_reg, dst_reg;
    logic        out_valid;
    logic [63:0] out_data;
    logic [3:0]  out_wen;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vsu_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .ext_field(ext_field), .src_field(src_field), .src_reg(src_reg),
        .dst_reg(dst_reg), .out_valid(out_valid), .out_data(out_data), .out_wen(out_wen)
    );

    function automatic logic [63:0] ref_mix(input logic [3:0] m, input logic [63:0] s, input logic [63:0] d);
        logic [63:0] r;
        for (int i = 0; i < 4; i++) r[i*16 +: 16] = m[i] ? d[i*16 +: 16] : s[i*16 +: 16];
        return r;
    endfunction

    function automatic logic [63:0] ref_swz(input logic [3:0] e, input logic [3:0] s, input logic [63:0] d);
        logic [7:0]  sel;
        logic [63:0] r;
        sel = {s, e};
        for (int i = 0; i < 4; i++) r[i*16 +: 16] = d[sel[i*2 +: 2]*16 +: 16];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, check at next negedge (one register stage)
    task automatic issue_and_check(input logic [3:0] op, input logic [3:0] e, input logic [3:0] s,
                                   input logic [63:0] sr, input logic [63:0] dr);
        logic [63:0] exp_d;
        logic [3:0]  exp_w;
        in_valid = 1'b1; op_code = op; ext_field = e; src_field = s; src_reg = sr; dst_reg = dr;
        if (op == 4'h4) begin exp_d = ref_mix(e, sr, dr); exp_w = ~e; end
        else begin exp_d = ref_swz(e, s, dr); exp_w = 4'hF; end
        @(negedge clk);
        chk(out_valid == 1'b1, "R6", {63'd0, out_valid}, 64'd1);
        chk(out_data == exp_d, (op == 4'h4) ? "R2" : "R4", out_data, exp_d);
        chk(out_wen == exp_w, (op == 4'h4) ? "R3" : "R5", {60'd0, out_wen}, {60'd0, exp_w});
    endtask

    task automatic idle_check(input logic [3:0] op, input bit v);
        logic [63:0] prev;
        prev = out_data;
        in_valid = v; op_code = op;
        src_reg = {$urandom, $urandom}; dst_reg = {$urandom, $urandom};
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", {63'd0, out_valid}, 64'd0);
        chk(out_data == prev, "R7", out_data, prev);
        chk(out_wen == 4'b0000, "R9", {60'd0, out_wen}, 64'd0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] d0, s0, r_a, r_b;
        void'($urandom(32'd1234));
        rst_n = 1'b0; in_valid = 1'b0; op_code = 4'h0; ext_field = 4'h0; src_field = 4'h0;
        src_reg = '0; dst_reg = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_wen == 4'b0 && out_data == 64'd0, "R1", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_wen == 4'b0 && out_data == 64'd0, "R1", out_data, 64'd0);

        d0 = 64'h4444_3333_2222_1111;
        s0 = 64'hDDDD_CCCC_BBBB_AAAA;
        // R2/R3: every mask
        for (int m = 0; m < 16; m++) issue_and_check(4'h4, m[3:0], 4'h0, s0, d0);
        // R4: identity, reverse, broadcast of each word
        issue_and_check(4'h5, 4'b0100, 4'b1110, s0, d0);
        issue_and_check(4'h5, 4'b1011, 4'b0001, s0, d0);
        for (int w = 0; w < 4; w++)
            issue_and_check(4'h5, {w[1:0], w[1:0]}, {w[1:0], w[1:0]}, s0, d0);
        // R6: single-cycle pulse after a lone request
        idle_check(4'h4, 1'b0);
        // R7: illegal opcodes with in_valid high
        for (int o = 0; o < 16; o++) if (o != 4 && o != 5) idle_check(o[3:0], 1'b1);

        // R8: swizzle ignores src_reg
        issue_and_check(4'h5, 4'b0110, 4'b1001, 64'h0, d0);
        r_a = out_data;
        issue_and_check(4'h5, 4'b0110, 4'b1001, 64'hFFFF_FFFF_FFFF_FFFF, d0);
        r_b = out_data;
        chk(r_a == r_b, "R8", r_b, r_a);

        // random mix of legal back-to-back and illegal gaps
        for (int n = 0; n < 300; n++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 4) issue_and_check(4'h4, 4'($urandom), 4'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
            else if (k < 8) issue_and_check(4'h5, 4'($urandom), 4'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
            else idle_check(4'($urandom_range(6, 15)), 1'($urandom));
        end

        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_wen == 4'b0, "R9", {60'd0, out_wen}, 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule